// File: doc/BRIEF.md
# Task-tagged instruction cache controller

This block holds the tag and valid state for a small set-associative instruction cache. It returns 128-bit fetch words to the core. Each line is tagged with its address tag and with the 8-bit identifier of the task that loaded it. Two tasks that fetch from the same virtual address therefore keep separate copies. A fetch that the memory management unit marks as shared is looked up and stored under task 0. A fetch marked non-cacheable goes straight from the refill port to the core and never touches the arrays.

Lookup is combinational, so a hit completes in the same cycle it is presented. On a miss the block raises a 128-bit aligned request to higher memory and holds it until memory acknowledges. The acknowledged word is forwarded to the core in that cycle and is written into the cache at the same clock edge. Each line is 256 bytes, divided into sixteen 16-byte words, and every word has its own valid bit. The replacement victim comes from a 7-bit tree pseudo-LRU per set. A per-way lock mask removes ways from replacement. A global lock stops all allocation. A one-cycle invalidate-all input clears every valid bit.

Top module: `task_icache`

## Requirements
- R1: While `mem_req` is high, `mem_addr` equals `fetch_addr` with bits [3:0] forced to zero.
- R2: A hit requires the stored address tag (`fetch_addr[31:10]`) and the stored task identifier to both equal the fetch's. A line loaded by one task does not hit for another task at the same address, and both lines can be resident at once.
- R3: When `attr_shared` is high, both lookup and allocation use task identifier 0 in place of `fetch_tid`.
- R4: A cacheable fetch that hits raises `fetch_valid` and `fetch_hit` in the same cycle, keeps `mem_req` low, and drives the stored word on `fetch_rdata`.
- R5: A fetch that misses holds `mem_req` high and `fetch_valid` low until a cycle with `mem_ack`. In that cycle `fetch_valid` is high and `fetch_rdata` equals `mem_rdata`, and the word is stored so that a later identical fetch hits.
- R6: A fetch with `attr_nocache` high never hits, is served from `mem_rdata`, and allocates nothing.
- R7: The set index is `fetch_addr[9:8]`. Each set keeps a 7-bit tree with node 0 as root and the children of node n at 2n+1 and 2n+2. A node bit of 0 sends the victim search toward the lower half of the ways, and 1 sends it toward the upper half. Every hit and every fill sets each node on the accessed way's path to point away from that way.
- R8: When a bit of `lock_mask` is set, that way is never chosen as a victim. At each tree node whose pointed half is fully locked, the search takes the other half. Hits in locked ways still count and update the tree.
- R9: While `lock_all` is high, no line is allocated or filled. Misses are served from `mem_rdata`, and hits are still served.
- R10: If every bit of `lock_mask` is set, a miss to a line that is not resident is served without allocation.
- R11: `inv_all` clears every line and word valid bit at the next clock edge. A fill requested in that cycle is dropped.
- R12: The word select is `fetch_addr[7:4]`. A miss on a missing word of a line that is already resident fills that word in the same way and keeps the line's other words. A fill that replaces a line clears all of that line's other word valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Invalidate every line at the next edge |
| lock_all | input | 1 | Global lock: no allocation |
| lock_mask | input | 8 | Per-way replacement lock |
| fetch_req | input | 1 | Core fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_tid | input | 8 | Current task identifier |
| attr_shared | input | 1 | Shared region: use task 0 |
| attr_nocache | input | 1 | Non-cacheable fetch |
| fetch_valid | output | 1 | Fetch word delivered this cycle |
| fetch_hit | output | 1 | Fetch served from the cache |
| fetch_rdata | output | 128 | Fetch word |
| mem_req | output | 1 | Request to higher memory |
| mem_addr | output | 32 | 16-byte aligned request address |
| mem_ack | input | 1 | Higher memory returns data this cycle |
| mem_rdata | input | 128 | Data from higher memory |

## Verification
The embedded assertions check several rules on every cycle. A hit never waits. An acknowledged miss always delivers. Invalidation empties the valid state. Non-cacheable fetches and global lock leave the valid bits untouched. Locked ways keep their tags. The tree changes only on a delivered cacheable fetch. Other properties appear only across the bench's scenarios, which compare each cycle against a behavioural model: which way a fill evicts, whether lines from different tasks coexist, shared-region aliasing, and how word valids survive a partial fill.

// File: rtl/task_icache.sv
module task_icache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 128,
  parameter int TID_W      = 8,
  parameter int WAYS       = 8,
  parameter int SETS       = 4,
  parameter int LINE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              lock_all,
  input  logic [WAYS-1:0]   lock_mask,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [TID_W-1:0]  fetch_tid,
  input  logic              attr_shared,
  input  logic              attr_nocache,
  output logic              fetch_valid,
  output logic              fetch_hit,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int CH_W   = OFF_W - BYTE_W;
  localparam int CHUNKS = 1 << CH_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINES  = SETS * WAYS;
  localparam int NODES  = WAYS - 1;
  localparam int KEY_W  = TID_W + TAG_W;

  logic [KEY_W-1:0]        key_q [LINES];
  logic [DATA_W-1:0]       word_q [LINES*CHUNKS];
  logic [LINES-1:0]        lv_q;
  logic [LINES*CHUNKS-1:0] cv_q;
  logic [SETS*NODES-1:0]   plru_q;

  logic [SET_W-1:0] set_i;
  logic [CH_W-1:0]  chk;
  logic [KEY_W-1:0] key;
  logic [NODES-1:0] tree;
  logic [WAY_W-1:0] mway, fway, uway;
  logic             line_hit, hit, alloc_ok, fill;
  int               hidx, fidx;
  logic             unused_lo;

  assign unused_lo = ^fetch_addr[BYTE_W-1:0];
  assign set_i = fetch_addr[OFF_W +: SET_W];
  assign chk   = fetch_addr[BYTE_W +: CH_W];
  assign key   = {attr_shared ? {TID_W{1'b0}} : fetch_tid, fetch_addr[ADDR_W-1 -: TAG_W]};
  assign tree  = plru_q[int'(set_i)*NODES +: NODES];

  function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] t, input logic [WAYS-1:0] lk);
    int node, lo, half;
    logic go_r, lfree, rfree;
    node = 0;
    lo = 0;
    for (int l = 0; l < WAY_W; l++) begin
      half  = WAYS >> (l + 1);
      lfree = 1'b0;
      rfree = 1'b0;
      for (int j = 0; j < WAYS; j++) begin
        if (j >= lo && j < lo + half && !lk[j]) lfree = 1'b1;
        if (j >= lo + half && j < lo + 2*half && !lk[j]) rfree = 1'b1;
      end
      go_r = t[node];
      if (go_r && !rfree) go_r = 1'b0;
      else if (!go_r && !lfree) go_r = 1'b1;
      if (go_r) lo = lo + half;
      node = 2*node + 1 + int'(go_r);
    end
    return WAY_W'(lo);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t, input logic [WAY_W-1:0] w);
    int node;
    logic b;
    logic [NODES-1:0] r;
    r = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      b = w[WAY_W-1-l];
      r[node] = ~b;
      node = 2*node + 1 + int'(b);
    end
    return r;
  endfunction

  always_comb begin
    line_hit = 1'b0;
    mway = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lv_q[int'(set_i)*WAYS + w] && key_q[int'(set_i)*WAYS + w] == key) begin
        line_hit = 1'b1;
        mway = WAY_W'(w);
      end
    end
  end

  assign hidx     = (int'(set_i)*WAYS + int'(mway))*CHUNKS + int'(chk);
  assign hit      = fetch_req && !attr_nocache && line_hit && cv_q[hidx];
  assign alloc_ok = !lock_all && (line_hit || !(&lock_mask));
  assign fill     = fetch_req && !attr_nocache && !hit && mem_ack && alloc_ok && !inv_all;
  assign fway     = line_hit ? mway : pick(tree, lock_mask);
  assign fidx     = int'(set_i)*WAYS + int'(fway);
  assign uway     = hit ? mway : fway;

  assign fetch_hit   = hit;
  assign fetch_valid = fetch_req && (hit || mem_ack);
  assign fetch_rdata = hit ? word_q[hidx] : mem_rdata;
  assign mem_req     = fetch_req && !hit;
  assign mem_addr    = {fetch_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q   <= '0;
      cv_q   <= '0;
      plru_q <= '0;
    end else begin
      if (inv_all) begin
        lv_q <= '0;
        cv_q <= '0;
      end else if (fill) begin
        lv_q[fidx] <= 1'b1;
        if (!line_hit)
          for (int c = 0; c < CHUNKS; c++) cv_q[fidx*CHUNKS + c] <= 1'b0;
        cv_q[fidx*CHUNKS + int'(chk)] <= 1'b1;
      end
      if (hit || fill)
        plru_q[int'(set_i)*NODES +: NODES] <= touch(tree, uway);
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      key_q[fidx] <= key;
      word_q[fidx*CHUNKS + int'(chk)] <= mem_rdata;
    end
  end

  // R4: a cacheable request that needs no memory is served at once
  p_nowait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !attr_nocache && !mem_req |-> fetch_valid && fetch_hit);
  // R5: an acknowledged miss delivers in the same cycle
  p_ack_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |-> fetch_valid);
  p_nocache_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && attr_nocache && !inv_all |=> $stable(lv_q) && $stable(cv_q));
  p_tree_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && !attr_nocache) |=> $stable(plru_q));
  p_global_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_all && !inv_all |=> $stable(lv_q) && $stable(cv_q));
  p_inv_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> lv_q == '0 && cv_q == '0);

  for (genvar g = 0; g < LINES; g++) begin : g_lockchk
    // R8: a locked way never receives a new tag
    p_lock_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_mask[g % WAYS] && lv_q[g] |=> $stable(key_q[g]));
  end
endmodule

// File: tb/sim_task_icache.sv
`timescale 1ns/1ps
module sim_task_icache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_all = 1'b0, lock_all = 1'b0;
  logic [7:0] lock_mask = '0;
  logic fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [7:0] fetch_tid = '0;
  logic attr_shared = 1'b0, attr_nocache = 1'b0;
  logic fetch_valid, fetch_hit, mem_req, mem_ack = 1'b0;
  logic [127:0] fetch_rdata, mem_rdata = '0;
  logic [31:0] mem_addr;

  int n_chk = 0, n_fail = 0, ser = 0;

  bit [29:0] m_key [4][8];
  bit        m_lv  [4][8];
  bit        m_cv  [4][8][16];
  bit [127:0] m_dat [4][8][16];
  bit        m_pl  [4][7];

  always #5 clk = ~clk;

  task_icache u0 (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .lock_all(lock_all), .lock_mask(lock_mask),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_tid(fetch_tid),
    .attr_shared(attr_shared), .attr_nocache(attr_nocache),
    .fetch_valid(fetch_valid), .fetch_hit(fetch_hit), .fetch_rdata(fetch_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  task automatic check(input string rq, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int victim(input int s, input bit [7:0] lk);
    int lo, n, w;
    bit lf, rf, r;
    lo = 0; n = 0; w = 8;
    repeat (3) begin
      w = w / 2;
      lf = 0; rf = 0;
      for (int j = lo; j < lo + w; j++) if (!lk[j]) lf = 1;
      for (int j = lo + w; j < lo + 2*w; j++) if (!lk[j]) rf = 1;
      r = m_pl[s][n];
      if (r && !rf) r = 0;
      else if (!r && !lf) r = 1;
      if (r) lo = lo + w;
      n = 2*n + 1 + int'(r);
    end
    return lo;
  endfunction

  task automatic touch(input int s, input int way);
    int n;
    bit b;
    n = 0;
    for (int l = 0; l < 3; l++) begin
      b = bit'((way >> (2 - l)) & 1);
      m_pl[s][n] = !b;
      n = 2*n + 1 + int'(b);
    end
  endtask

  task automatic step(input bit req, input logic [31:0] a, input logic [7:0] tid, input bit sh,
                      input bit nc, input bit ack, input bit [7:0] lk, input bit gl, input bit inv,
                      input string rq);
    int s, c, fw, way;
    bit found, hit, fill;
    bit [29:0] k;
    logic [127:0] md;
    ser++;
    md = {a, 24'h0, tid, 32'(ser), 32'hFACE0000 ^ 32'(ser)};
    fetch_req = req; fetch_addr = a; fetch_tid = tid; attr_shared = sh; attr_nocache = nc;
    mem_ack = ack; mem_rdata = md; lock_mask = lk; lock_all = gl; inv_all = inv;
    #1;
    s = int'(a[9:8]); c = int'(a[7:4]);
    k = {sh ? 8'h00 : tid, a[31:10]};
    found = 0; fw = 0;
    for (int w = 0; w < 8; w++) if (m_lv[s][w] && m_key[s][w] == k) begin found = 1; fw = w; end
    hit = req && !nc && found && m_cv[s][fw][c];
    check(rq, "fetch_hit", 128'(fetch_hit), 128'(hit));
    check(rq, "fetch_valid", 128'(fetch_valid), 128'(req && (hit || ack)));
    check(rq, "mem_req", 128'(mem_req), 128'(req && !hit));
    if (req && (hit || ack)) check(rq, "fetch_rdata", fetch_rdata, hit ? m_dat[s][fw][c] : md);
    if (req && !hit) check("R1", "mem_addr", 128'(mem_addr), 128'({a[31:4], 4'h0}));
    fill = req && !nc && !hit && ack && !gl && (found || lk != 8'hFF) && !inv;
    way = found ? fw : victim(s, lk);
    @(posedge clk);
    if (inv) begin
      for (int i = 0; i < 4; i++) for (int w = 0; w < 8; w++) begin
        m_lv[i][w] = 0;
        for (int j = 0; j < 16; j++) m_cv[i][w][j] = 0;
      end
    end else if (fill) begin
      if (!found) for (int j = 0; j < 16; j++) m_cv[s][way][j] = 0;
      m_lv[s][way] = 1; m_key[s][way] = k; m_cv[s][way][c] = 1; m_dat[s][way][c] = md;
    end
    if (hit) touch(s, fw);
    else if (fill) touch(s, way);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] a_, b_, c_, d_;
    for (int i = 0; i < 4; i++) for (int w = 0; w < 8; w++) begin
      m_lv[i][w] = 0;
      for (int j = 0; j < 16; j++) m_cv[i][w][j] = 0;
    end
    for (int i = 0; i < 4; i++) for (int n = 0; n < 7; n++) m_pl[i][n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    a_ = 32'h0001_0040; b_ = 32'h0002_0150; c_ = 32'h0003_0260; d_ = 32'h0004_0370;
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R4");
    step(1, a_, 5, 0, 0, 1, 8'h00, 0, 0, "R5");
    step(1, a_, 5, 0, 0, 1, 8'h00, 0, 0, "R4");
    step(1, a_, 6, 0, 0, 1, 8'h00, 0, 0, "R2");
    step(1, a_, 5, 0, 0, 0, 8'h00, 0, 0, "R2");
    step(1, a_, 6, 0, 0, 0, 8'h00, 0, 0, "R2");
    step(1, b_, 5, 0, 0, 0, 8'h00, 0, 0, "R5");
    step(1, b_, 5, 0, 0, 0, 8'h00, 0, 0, "R5");
    step(1, b_, 5, 0, 0, 1, 8'h00, 0, 0, "R5");
    step(1, b_, 5, 0, 0, 0, 8'h00, 0, 0, "R4");
    step(1, b_ + 32'h10, 5, 0, 0, 1, 8'h00, 0, 0, "R12");
    step(1, b_, 5, 0, 0, 0, 8'h00, 0, 0, "R12");
    step(1, b_ + 32'h10, 5, 0, 0, 0, 8'h00, 0, 0, "R12");
    step(1, c_, 7, 1, 0, 1, 8'h00, 0, 0, "R3");
    step(1, c_, 9, 1, 0, 0, 8'h00, 0, 0, "R3");
    step(1, c_, 9, 0, 0, 0, 8'h00, 0, 0, "R3");
    step(1, d_, 1, 0, 1, 1, 8'h00, 0, 0, "R6");
    step(1, d_, 1, 0, 1, 1, 8'h00, 0, 0, "R6");
    step(1, d_, 1, 0, 0, 0, 8'h00, 0, 0, "R6");
    for (int i = 0; i < 12; i++) step(1, 32'h0100_0000 + (i << 10), 2, 0, 0, 1, 8'h00, 0, 0, "R7");
    for (int i = 0; i < 12; i++) step(1, 32'h0100_0000 + (i << 10), 2, 0, 0, 0, 8'h00, 0, 0, "R7");
    for (int i = 0; i < 10; i++) step(1, 32'h0200_0000 + (i << 10), 3, 0, 0, 1, 8'h0F, 0, 0, "R8");
    for (int i = 0; i < 12; i++) step(1, 32'h0100_0000 + (i << 10), 2, 0, 0, 0, 8'h0F, 0, 0, "R8");
    step(1, 32'h0300_0100, 4, 0, 0, 1, 8'h00, 1, 0, "R9");
    step(1, 32'h0300_0100, 4, 0, 0, 0, 8'h00, 1, 0, "R9");
    step(1, b_, 5, 0, 0, 0, 8'h00, 1, 0, "R9");
    step(1, 32'h0400_0200, 4, 0, 0, 1, 8'hFF, 0, 0, "R10");
    step(1, 32'h0400_0200, 4, 0, 0, 0, 8'hFF, 0, 0, "R10");
    step(1, b_, 5, 0, 0, 0, 8'hFF, 0, 0, "R10");
    step(1, b_, 5, 0, 0, 1, 8'h00, 0, 1, "R11");
    step(1, b_, 5, 0, 0, 0, 8'h00, 0, 0, "R11");
    step(1, a_, 6, 0, 0, 0, 8'h00, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R4");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule